// File: doc/BRIEF.md
# BCD Clock-Calendar With Double-Buffered Update

This block keeps time from seconds up to a two-digit year in packed BCD, advancing once for every one-second tick it receives from an external prescaler. It holds two copies of the time: a working copy that the update logic advances, and a user copy that software reads and writes through a small byte-wide register port. After each tick an update sequence runs. It first raises an update-in-progress flag and holds it for a programmable warning window. It then advances the working copy, with full carry through day of week, date, month and year, and leap years handled. Finally it copies the working copy into the user copy.

Software that wants to set a new time asserts the freeze input. While freeze is high the sequence still runs every second, so timekeeping never stops, but the user copy is not overwritten and software can write a consistent set of fields. On the clock edge where freeze drops, the written user copy is loaded into the working copy. Seconds, minutes and hours each have an alarm byte. The block sends two one-cycle pulses to the interrupt logic: update-ended and alarm-match.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Seconds and minutes count 00..59 in BCD. Rolling over from 59 to 00 carries into the next field.
- R2: With `h24_i`=1 the hours byte counts 00..23, and the step from 23 to 00 advances the day.
- R3: With `h24_i`=0, hours bit 7 is the PM flag and bits 6:0 hold BCD 01..12. The order is 12 AM (0x12), 01..11 AM, 12 PM (0x92), 01..11 PM (0x81..0x91), and then back to 12 AM. The step from 11 PM to 12 AM advances the day.
- R4: A day advance wraps day of week from 7 to 1 and the date from the last day of the month to 01. A month wraps from 12 to 01 and a year from 99 to 00. February has 29 days when the year value is divisible by 4, and 28 days otherwise.
- R5: `uip_o` rises on the first clock edge after a sampled tick and stays high for UIP_LEAD+2 cycles. It falls on the edge where the transfer lands.
- R6: When not frozen, the edge that lowers `uip_o` writes the advanced time into the user copy and raises `upd_o` for exactly one cycle.
- R7: While `freeze_i` is high, the user copy keeps its contents across an update, `upd_o` stays low, and `uip_o` still runs its window.
- R8: On the edge where `freeze_i` falls, the user copy is loaded into the working copy. The next update then yields the written time plus one second.
- R9: `alarm_o` pulses for one cycle, together with the transfer edge, when the advanced seconds, minutes and hours each equal their alarm byte. An alarm byte with bits 7:6 = 11 matches any value. The alarm works while frozen.
- R10: Register addresses are 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 date, 8 month, 9 year. After reset the time reads 00:00:00, day 1, 01-01-00, and the alarm bytes read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle one-second tick from the prescaler |
| freeze_i | input | 1 | Hold the user copy and allow software to set the time |
| h24_i | input | 1 | Hours format: 1 = 24-hour, 0 = 12-hour with PM flag |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| uip_o | output | 1 | Update in progress |
| upd_o | output | 1 | Update-ended pulse |
| alarm_o | output | 1 | Alarm-match pulse |

## Verification
A tick sampled at edge E0 shows as `uip_o` high from the edge E0 onward. The working copy advances at edge E0+UIP_LEAD+1. `upd_o`, `alarm_o` and the new user copy all appear at edge E0+UIP_LEAD+2, which is also where `uip_o` falls. The bench drives the tick on a falling edge and counts falling edges. It checks `uip_o` right after E0 and again just before the transfer. It samples the pulses and reads the registers back after E0+UIP_LEAD+2, and it checks one cycle later that the pulses have ended. Because `rdata_o` is combinational, reads are taken a few ns after a falling edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_WAIT, SEQ_ADV, SEQ_XFER} seq_state_e;

  localparam int unsigned ADR_SEC  = 0;
  localparam int unsigned ADR_ASEC = 1;
  localparam int unsigned ADR_MIN  = 2;
  localparam int unsigned ADR_AMIN = 3;
  localparam int unsigned ADR_HR   = 4;
  localparam int unsigned ADR_AHR  = 5;
  localparam int unsigned ADR_DOW  = 6;
  localparam int unsigned ADR_DATE = 7;
  localparam int unsigned ADR_MON  = 8;
  localparam int unsigned ADR_YR   = 9;

  localparam rtc_time_t RST_TIME = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                     dow: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [6:0] yb;
    yb = {3'b000, yr[7:4]} * 7'd10 + {3'b000, yr[3:0]};
    return (yb[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_calendar_next.sv
module rtc_calendar_next
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  input  logic      h24_i,
  output rtc_time_t nxt_o
);
  logic sec_c, min_c, day_c, mon_c, yr_c;
  logic [6:0] hv;
  logic       pm;

  assign hv = cur_i.hr[6:0];
  assign pm = cur_i.hr[7];

  always_comb begin
    nxt_o = cur_i;
    sec_c = (cur_i.sec == 8'h59);
    nxt_o.sec = sec_c ? 8'h00 : bcd_inc(cur_i.sec);

    min_c = sec_c && (cur_i.min == 8'h59);
    if (sec_c) nxt_o.min = (cur_i.min == 8'h59) ? 8'h00 : bcd_inc(cur_i.min);

    day_c = 1'b0;
    if (min_c) begin
      if (h24_i) begin
        day_c = (cur_i.hr == 8'h23);
        nxt_o.hr = day_c ? 8'h00 : bcd_inc(cur_i.hr);
      end else if (hv == 7'h12) begin
        nxt_o.hr = {pm, 7'h01};
      end else if (hv == 7'h11) begin
        // 11 AM -> 12 PM, 11 PM -> 12 AM with day carry
        day_c    = pm;
        nxt_o.hr = pm ? 8'h12 : 8'h92;
      end else begin
        nxt_o.hr = {pm, bcd_inc({1'b0, hv})};
        nxt_o.hr[7] = pm;
      end
    end

    mon_c = 1'b0;
    yr_c  = 1'b0;
    if (day_c) begin
      nxt_o.dow = (cur_i.dow == 8'h07) ? 8'h01 : bcd_inc(cur_i.dow);
      mon_c = (cur_i.date == month_last(cur_i.mon, cur_i.yr));
      nxt_o.date = mon_c ? 8'h01 : bcd_inc(cur_i.date);
      if (mon_c) begin
        yr_c = (cur_i.mon == 8'h12);
        nxt_o.mon = yr_c ? 8'h01 : bcd_inc(cur_i.mon);
        if (yr_c) nxt_o.yr = (cur_i.yr == 8'h99) ? 8'h00 : bcd_inc(cur_i.yr);
      end
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int unsigned NUM_FIELDS = 3
) (
  input  logic [NUM_FIELDS-1:0][7:0] cur_i,
  input  logic [NUM_FIELDS-1:0][7:0] alm_i,
  output logic                       hit_o
);
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    assign fld_ok[i] = (alm_i[i][7:6] == 2'b11) || (alm_i[i] == cur_i[i]);
  end

  assign hit_o = &fld_ok;
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
  import rtc_pkg::*;
#(
  parameter int unsigned UIP_LEAD = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic uip_o,
  output logic adv_o,
  output logic xfer_o
);
  localparam int unsigned CNT_W = $clog2(UIP_LEAD + 1);
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(UIP_LEAD - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (tick_i) begin
          state_q <= SEQ_WAIT;
          cnt_q   <= CNT_START;
        end
        SEQ_WAIT: begin
          if (cnt_q == '0) state_q <= SEQ_ADV;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        SEQ_ADV:  state_q <= SEQ_XFER;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign uip_o  = (state_q != SEQ_IDLE);
  assign adv_o  = (state_q == SEQ_ADV);
  assign xfer_o = (state_q == SEQ_XFER);

  AST_UIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uip_o) |=> uip_o) else $error("uip dropped early"); // R5
  AST_ADV_BEFORE_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> $past(adv_o)) else $error("transfer without advance"); // R5
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_pkg::*;
#(
  parameter int unsigned UIP_LEAD = 8,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              freeze_i,
  input  logic              h24_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              uip_o,
  output logic              upd_o,
  output logic              alarm_o
);
  localparam int unsigned NUM_ALM = 3;

  rtc_time_t                work_q, user_q, work_nxt;
  logic [NUM_ALM-1:0][7:0]  alm_q;
  logic [NUM_ALM-1:0][7:0]  cmp_cur;
  logic                     freeze_q, upd_q, alarm_q;
  logic                     adv, xfer, hit, load;

  rtc_update_seq #(.UIP_LEAD(UIP_LEAD)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .uip_o  (uip_o),
    .adv_o  (adv),
    .xfer_o (xfer)
  );

  rtc_calendar_next i_next (
    .cur_i (work_q),
    .h24_i (h24_i),
    .nxt_o (work_nxt)
  );

  assign cmp_cur = {work_q.hr, work_q.min, work_q.sec};

  rtc_alarm_match #(.NUM_FIELDS(NUM_ALM)) i_alm (
    .cur_i (cmp_cur),
    .alm_i (alm_q),
    .hit_o (hit)
  );

  assign load = freeze_q && !freeze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q   <= RST_TIME;
      freeze_q <= 1'b0;
      upd_q    <= 1'b0;
      alarm_q  <= 1'b0;
    end else begin
      freeze_q <= freeze_i;
      upd_q    <= xfer && !freeze_i;
      alarm_q  <= xfer && hit;
      // software-set time wins over a coinciding advance
      if (load)     work_q <= user_q;
      else if (adv) work_q <= work_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      user_q <= RST_TIME;
    end else if (xfer && !freeze_i) begin
      user_q <= work_q;
    end else if (wr_en_i) begin
      case (int'(addr_i))
        ADR_SEC:  user_q.sec  <= wdata_i;
        ADR_MIN:  user_q.min  <= wdata_i;
        ADR_HR:   user_q.hr   <= wdata_i;
        ADR_DOW:  user_q.dow  <= wdata_i;
        ADR_DATE: user_q.date <= wdata_i;
        ADR_MON:  user_q.mon  <= wdata_i;
        ADR_YR:   user_q.yr   <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q <= '0;
    end else if (wr_en_i) begin
      case (int'(addr_i))
        ADR_ASEC: alm_q[0] <= wdata_i;
        ADR_AMIN: alm_q[1] <= wdata_i;
        ADR_AHR:  alm_q[2] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (int'(addr_i))
      ADR_SEC:  rdata_o = user_q.sec;
      ADR_ASEC: rdata_o = alm_q[0];
      ADR_MIN:  rdata_o = user_q.min;
      ADR_AMIN: rdata_o = alm_q[1];
      ADR_HR:   rdata_o = user_q.hr;
      ADR_AHR:  rdata_o = alm_q[2];
      ADR_DOW:  rdata_o = user_q.dow;
      ADR_DATE: rdata_o = user_q.date;
      ADR_MON:  rdata_o = user_q.mon;
      ADR_YR:   rdata_o = user_q.yr;
      default:  rdata_o = 8'h00;
    endcase
  end

  assign upd_o   = upd_q;
  assign alarm_o = alarm_q;

  AST_UIP_LEADS_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(uip_o)) else $error("update without warning"); // R5
  AST_UPD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o) else $error("update pulse too long"); // R6
  AST_NO_UPD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> !$past(freeze_i)) else $error("update while frozen"); // R7
  AST_LOAD_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_q && !freeze_i) |=> (work_q == $past(user_q))) else $error("release load"); // R8
  AST_ALARM_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> $past(uip_o)) else $error("alarm outside update"); // R9
endmodule

// File: tb/test_rtc_bcd_calendar.sv
module test_rtc_bcd_calendar;
  localparam int unsigned LEAD = 8;

  typedef struct packed {
    int s; int m; int h; int dw; int dt; int mo; int yr;
  } tm_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, freeze = 1'b0, h24 = 1'b1, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       uip, upd, alarm;
  int         checks = 0, fails = 0;

  rtc_bcd_calendar #(.UIP_LEAD(LEAD), .ADDR_W(4)) i_rtc_bcd_calendar (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .freeze_i(freeze), .h24_i(h24),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .uip_o(uip), .upd_o(upd), .alarm_o(alarm)
  );

  always #10 clk = ~clk;

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dim(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic tm_t tm_next(tm_t t);
    tm_t n = t;
    n.s = t.s + 1;
    if (n.s == 60) begin
      n.s = 0; n.m = t.m + 1;
      if (n.m == 60) begin
        n.m = 0; n.h = t.h + 1;
        if (n.h == 24) begin
          n.h = 0;
          n.dw = (t.dw == 7) ? 1 : t.dw + 1;
          n.dt = t.dt + 1;
          if (n.dt > dim(t.mo, t.yr)) begin
            n.dt = 1; n.mo = t.mo + 1;
            if (n.mo == 13) begin n.mo = 1; n.yr = (t.yr + 1) % 100; end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] hr_enc(int h, bit fmt24);
    if (fmt24) return bcd(h);
    if (h == 0) return 8'h12;
    if (h < 12) return bcd(h);
    if (h == 12) return 8'h92;
    return 8'h80 | bcd(h - 12);
  endfunction

  task automatic write_reg(input int a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic read_reg(input int a, output logic [7:0] d);
    addr = 4'(a); #2; d = rdata;
  endtask

  task automatic set_time(input tm_t t);
    @(negedge clk); freeze = 1'b1;
    write_reg(0, bcd(t.s)); write_reg(2, bcd(t.m)); write_reg(4, hr_enc(t.h, h24));
    write_reg(6, bcd(t.dw)); write_reg(7, bcd(t.dt)); write_reg(8, bcd(t.mo));
    write_reg(9, bcd(t.yr));
    @(negedge clk); freeze = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_time(input tm_t t, input string req);
    logic [7:0] v;
    logic [55:0] act, exp;
    read_reg(9, v); act[55:48] = v; read_reg(8, v); act[47:40] = v;
    read_reg(7, v); act[39:32] = v; read_reg(6, v); act[31:24] = v;
    read_reg(4, v); act[23:16] = v; read_reg(2, v); act[15:8] = v;
    read_reg(0, v); act[7:0] = v;
    exp = {bcd(t.yr), bcd(t.mo), bcd(t.dt), bcd(t.dw), hr_enc(t.h, h24), bcd(t.m), bcd(t.s)};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%014h expected=%014h", req, act, exp);
    end
  endtask

  // one tick through the whole update window
  task automatic one_second(input bit exp_upd, input bit exp_alarm, input string req);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk(uip === 1'b1, "R5 uip after tick", int'(uip), 1);
    repeat (LEAD + 1) @(negedge clk);
    chk(uip === 1'b1 && upd === 1'b0, "R5 uip held before transfer", int'({uip, upd}), 2);
    @(negedge clk);
    chk(uip === 1'b0, "R5 uip falls at transfer", int'(uip), 0);
    chk(upd === exp_upd, {req, " R6/R7 upd"}, int'(upd), int'(exp_upd));
    chk(alarm === exp_alarm, {req, " R9 alarm"}, int'(alarm), int'(exp_alarm));
    @(negedge clk);
    chk(upd === 1'b0 && alarm === 1'b0, "R6 single pulse", int'({upd, alarm}), 0);
  endtask

  task automatic run_case(input tm_t t, input bit fmt24, input string req);
    tm_t n;
    h24 = fmt24;
    set_time(t);
    write_reg(1, 8'hC0); write_reg(3, 8'hC0); write_reg(5, 8'hC0);
    n = tm_next(t);
    one_second(1'b1, 1'b1, req);
    check_time(n, req);
  endtask

  initial begin
    logic [7:0] v;
    tm_t t, n;
    void'($urandom(32'd1977));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    t = '{s: 0, m: 0, h: 0, dw: 1, dt: 1, mo: 1, yr: 0};
    check_time(t, "R10 reset time");
    read_reg(1, v); chk(v == 8'h00, "R10 reset sec alarm", int'(v), 0);
    read_reg(5, v); chk(v == 8'h00, "R10 reset hour alarm", int'(v), 0);
    chk(uip === 1'b0 && upd === 1'b0, "R10 reset outputs", int'({uip, upd}), 0);
    write_reg(3, 8'h42); read_reg(3, v); chk(v == 8'h42, "R10 alarm reg rw", int'(v), 8'h42);

    // R1 basic and carries
    run_case('{s: 5, m: 10, h: 3, dw: 2, dt: 4, mo: 5, yr: 21}, 1'b1, "R1 seconds");
    run_case('{s: 59, m: 41, h: 3, dw: 2, dt: 4, mo: 5, yr: 21}, 1'b1, "R1 minute carry");
    // R2
    run_case('{s: 59, m: 59, h: 9, dw: 2, dt: 4, mo: 5, yr: 21}, 1'b1, "R2 hour carry");
    run_case('{s: 59, m: 59, h: 23, dw: 7, dt: 30, mo: 6, yr: 21}, 1'b1, "R2 R4 day and month");
    // R3 twelve-hour sequence
    run_case('{s: 59, m: 59, h: 11, dw: 3, dt: 9, mo: 3, yr: 22}, 1'b0, "R3 11AM to 12PM");
    run_case('{s: 59, m: 59, h: 12, dw: 3, dt: 9, mo: 3, yr: 22}, 1'b0, "R3 12PM to 1PM");
    run_case('{s: 59, m: 59, h: 23, dw: 3, dt: 9, mo: 3, yr: 22}, 1'b0, "R3 11PM to 12AM");
    run_case('{s: 59, m: 59, h: 0, dw: 3, dt: 9, mo: 3, yr: 22}, 1'b0, "R3 12AM to 1AM");
    // R4 leap and year wrap
    run_case('{s: 59, m: 59, h: 23, dw: 1, dt: 28, mo: 2, yr: 24}, 1'b1, "R4 leap 28");
    run_case('{s: 59, m: 59, h: 23, dw: 1, dt: 29, mo: 2, yr: 24}, 1'b1, "R4 leap 29");
    run_case('{s: 59, m: 59, h: 23, dw: 1, dt: 28, mo: 2, yr: 23}, 1'b1, "R4 non-leap");
    run_case('{s: 59, m: 59, h: 23, dw: 6, dt: 31, mo: 12, yr: 99}, 1'b1, "R4 year wrap");

    // R7 freeze: user copy holds, no upd, alarm still fires
    h24 = 1'b1;
    t = '{s: 20, m: 30, h: 14, dw: 4, dt: 15, mo: 8, yr: 30};
    set_time(t);
    @(negedge clk); freeze = 1'b1;
    t = '{s: 45, m: 12, h: 7, dw: 5, dt: 2, mo: 9, yr: 31};
    write_reg(0, bcd(t.s)); write_reg(2, bcd(t.m)); write_reg(4, hr_enc(t.h, 1'b1));
    write_reg(6, bcd(t.dw)); write_reg(7, bcd(t.dt)); write_reg(8, bcd(t.mo));
    write_reg(9, bcd(t.yr));
    one_second(1'b0, 1'b1, "R7 frozen");
    check_time(t, "R7 user copy held");
    // R8 release loads written time
    @(negedge clk); freeze = 1'b0;
    repeat (2) @(negedge clk);
    write_reg(1, bcd(46)); write_reg(3, bcd(12)); write_reg(5, bcd(7));
    one_second(1'b1, 1'b1, "R8 R9 release exact alarm");
    check_time(tm_next(t), "R8 after release");

    // R9 mismatch: seconds differ
    write_reg(1, bcd(10)); write_reg(3, 8'hC0); write_reg(5, 8'hC0);
    one_second(1'b1, 1'b0, "R9 no match");

    // constrained random
    for (int i = 0; i < 40; i++) begin
      int mode;
      bit fmt;
      fmt = 1'($urandom % 2);
      t.yr = int'($urandom % 100);
      t.mo = 1 + int'($urandom % 12);
      t.dt = ($urandom % 2) ? dim(t.mo, t.yr) : 1 + int'($urandom % dim(t.mo, t.yr));
      t.h  = int'($urandom % 24);
      t.m  = ($urandom % 2) ? 59 : int'($urandom % 60);
      t.s  = ($urandom % 3 != 0) ? 59 : int'($urandom % 60);
      t.dw = 1 + int'($urandom % 7);
      h24 = fmt;
      set_time(t);
      n = tm_next(t);
      mode = int'($urandom % 3);
      if (mode == 0) begin
        write_reg(1, 8'hC0 | 8'($urandom % 64)); write_reg(3, 8'hFF); write_reg(5, 8'hC5);
      end else if (mode == 1) begin
        write_reg(1, bcd(n.s)); write_reg(3, bcd(n.m)); write_reg(5, hr_enc(n.h, fmt));
      end else begin
        write_reg(1, bcd((n.s + 1) % 60)); write_reg(3, 8'hC0); write_reg(5, 8'hC0);
      end
      one_second(1'b1, mode != 2, "R1-random R9");
      check_time(n, "R4 R2 R3 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule